// File: doc/BRIEF.md
# Serial-to-Parallel Latched Output Driver

This block is the logic core of a cascadable 32-channel serial-in, parallel-out display driver. Serial data enters a 32-stage register one bit per falling edge of an external shift clock, and the last stage is presented on a serial output so that several drivers can be chained. A level-sensitive latch bank takes a copy of the register while the latch enable is high and keeps it while the enable is low. A per-channel output stage then combines each latched bit with a blanking input and a polarity input to give 32 on/off commands for the external drivers.

Everything runs on one faster system clock. The external shift clock, serial data and latch enable are passed through synchronizers, a detected falling edge of the shift clock acts as the shift enable, and the latch copies the register on every system cycle while the synchronized enable is high. The on/off vector is a purely combinational function of the latches, blanking and polarity.

Top module: `serial_latch_driver`

## Requirements
- R1: On each falling edge of `shift_clk` the register advances one place: stage 1 (bit 0) takes `ser_din` and stage n+1 takes the old stage n; a rising edge or a steady `shift_clk` leaves the register unchanged.
- R2: `ser_dout` always equals the last stage (bit 31), so the first bit shifted in appears on `ser_dout` after 32 falling edges and the second bit after 33.
- R3: `latch_en`, `blank_n` and `polarity` have no effect on the register: shifting proceeds identically whatever their levels.
- R4: While `latch_en` is high the latches follow the register, so a register change made during that time reaches the outputs.
- R5: While `latch_en` is low the latches hold, and with `blank_n` and `polarity` held the outputs do not change however many bits are shifted.
- R6: With `blank_n` = 0 and `polarity` = 0 every bit of `out_on` is 1 (all on), whatever the latches hold.
- R7: With `blank_n` = 0 and `polarity` = 1 every bit of `out_on` is 0 (all off), whatever the latches hold.
- R8: With `blank_n` = 1 and `polarity` = 1, `out_on[n]` equals latch bit n.
- R9: With `blank_n` = 1 and `polarity` = 0, `out_on[n]` is the inverse of latch bit n.
- R10: A low `rst_n` sampled on a rising `clk` edge clears the register and the latches to zero.
- R11: `out_on` responds to `blank_n` and `polarity` combinationally, in the same cycle, with no register in that path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk | input | 1 | External shift clock, shifts on its falling edge |
| ser_din | input | 1 | Serial data into stage 1 |
| latch_en | input | 1 | High: latches transparent; low: latches hold |
| blank_n | input | 1 | Low forces all outputs to one level chosen by polarity |
| polarity | input | 1 | High: true latch data; low: inverted data |
| ser_dout | output | 1 | Last register stage, for cascading |
| out_on | output | 32 | Per-channel on/off command |

## Verification
The assertions check on every cycle that a detected falling edge moves each stage into the next, that no shift happens without one, that the latches copy the register while enabled and stay stable while not, and that the output vector obeys the four blanking and polarity cases against the latch contents. Only the bench scenarios show end-to-end effects: that a bit entered at the serial input reaches the serial output after exactly 32 edges and is replaced after the 33rd, that toggling the control inputs during shifting leaves the shifted data intact, and that a register change under an open latch reaches the outputs while a closed latch hides long runs of shifting.

// File: rtl/sld_pkg.sv
// Package: shared types and helpers for the serial latched driver.
// Assumes: the four output modes are fully decoded from two inputs.
package sld_pkg;

    typedef enum logic [1:0] {
        MODE_ALL_ON  = 2'b00,
        MODE_ALL_OFF = 2'b01,
        MODE_INVERT  = 2'b10,
        MODE_NORMAL  = 2'b11
    } drive_mode_e;

    // Map {blank_n, polarity} onto the output mode.
    function automatic drive_mode_e decode_mode(input logic blank_n, input logic polarity);
        drive_mode_e m;
        case ({blank_n, polarity})
            2'b00:   m = MODE_ALL_ON;
            2'b01:   m = MODE_ALL_OFF;
            2'b10:   m = MODE_INVERT;
            default: m = MODE_NORMAL;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/sld_input_sync.sv
// Module: sld_input_sync
// Brings the external shift clock, serial data and latch enable into the
// system clock domain and turns a falling shift clock into a one-cycle
// shift enable. Data and enable share the clock's sync depth so the data
// sampled with an edge was stable around that edge.
// Assumes: external inputs stay stable for more than SYNC_STAGES+1 cycles.
module sld_input_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_clk,
    input  logic ser_din,
    input  logic latch_en,
    output logic shift_en,
    output logic din_s,
    output logic le_s
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] clk_pipe;
    logic [LAST:0] din_pipe;
    logic [LAST:0] le_pipe;
    logic          clk_prev;

    // Synchronizer chains for the three asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_pipe <= '0;
            din_pipe <= '0;
            le_pipe  <= '0;
            clk_prev <= 1'b0;
        end else begin
            clk_pipe <= {clk_pipe[LAST-1:0], shift_clk};
            din_pipe <= {din_pipe[LAST-1:0], ser_din};
            le_pipe  <= {le_pipe[LAST-1:0], latch_en};
            clk_prev <= clk_pipe[LAST];
        end
    end

    // Falling-edge detect on the synchronized shift clock.
    always_comb begin
        shift_en = clk_prev & ~clk_pipe[LAST];
        din_s    = din_pipe[LAST];
        le_s     = le_pipe[LAST];
    end

    // A detected edge lasts exactly one system cycle.
    p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> !shift_en);

endmodule

// File: rtl/sld_shift_chain.sv
// Module: sld_shift_chain
// Serial-in shift register: stage 1 (bit 0) takes the serial input and each
// stage passes to the next on a shift enable. The last stage is the
// cascade output.
// Assumes: shift_en is a single-cycle pulse per external falling edge.
module sld_shift_chain #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] stages,
    output logic             dout
);
    // Advance the chain on each shift enable; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stages <= '0;
        else if (shift_en)
            stages <= {stages[WIDTH-2:0], din};
    end

    // Cascade output is the last stage.
    always_comb dout = stages[WIDTH-1];

    // Each stage takes the value of its predecessor on a shift.
    p_advance_r1: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> stages[WIDTH-1:1] == $past(stages[WIDTH-2:0]));

    // Without a detected edge the register does not move.
    p_no_spurious_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(stages));

endmodule

// File: rtl/sld_latch_bank.sv
// Module: sld_latch_bank
// Level-sensitive latch bank modelled synchronously: copies the register on
// every system cycle while the enable is high and holds while it is low.
// Assumes: enable is already synchronized to clk.
module sld_latch_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             le,
    input  logic [WIDTH-1:0] stages,
    output logic [WIDTH-1:0] held
);
    // Transparent while enabled, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held <= '0;
        else if (le)
            held <= stages;
    end

    p_transparent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> held == $past(stages));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !le |=> $stable(held));

endmodule

// File: rtl/sld_output_stage.sv
// Module: sld_output_stage
// Per-channel combinational drive logic: blanking and polarity select
// all-on, all-off, inverted or true latch data for each output.
// Assumes: no register in this path; control inputs act at once.
module sld_output_stage
    import sld_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             blank_n,
    input  logic             polarity,
    input  logic [WIDTH-1:0] held,
    output logic [WIDTH-1:0] out_on
);
    drive_mode_e mode;

    // Decode the shared mode once for all channels.
    always_comb mode = decode_mode(blank_n, polarity);

    for (genvar ch = 0; ch < WIDTH; ch++) begin : g_chan
        // Select this channel's command from the mode.
        always_comb begin
            case (mode)
                MODE_ALL_ON:  out_on[ch] = 1'b1;
                MODE_ALL_OFF: out_on[ch] = 1'b0;
                MODE_INVERT:  out_on[ch] = ~held[ch];
                default:      out_on[ch] = held[ch];
            endcase
        end
    end

endmodule

// File: rtl/serial_latch_driver.sv
// Module: serial_latch_driver (top)
// Cascadable serial-in, parallel-out latched driver core: synchronizer and
// edge detect, shift chain, latch bank and per-channel output stage.
// Assumes: clk runs several times faster than shift_clk; rst_n is
// synchronous and active low.
module serial_latch_driver #(
    parameter int WIDTH       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_clk,
    input  logic             ser_din,
    input  logic             latch_en,
    input  logic             blank_n,
    input  logic             polarity,
    output logic             ser_dout,
    output logic [WIDTH-1:0] out_on
);
    logic             shift_en;
    logic             din_s;
    logic             le_s;
    logic [WIDTH-1:0] stages;
    logic [WIDTH-1:0] held;

    sld_input_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_clk(shift_clk),
        .ser_din  (ser_din),
        .latch_en (latch_en),
        .shift_en (shift_en),
        .din_s    (din_s),
        .le_s     (le_s)
    );

    sld_shift_chain #(.WIDTH(WIDTH)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_en(shift_en),
        .din     (din_s),
        .stages  (stages),
        .dout    (ser_dout)
    );

    sld_latch_bank #(.WIDTH(WIDTH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .le    (le_s),
        .stages(stages),
        .held  (held)
    );

    sld_output_stage #(.WIDTH(WIDTH)) u_out (
        .blank_n (blank_n),
        .polarity(polarity),
        .held    (held),
        .out_on  (out_on)
    );

    p_all_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_n && !polarity) |-> (out_on == {WIDTH{1'b1}}));

    p_all_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!blank_n && polarity) |-> (out_on == '0));

    p_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && polarity) |-> (out_on == held));

    p_invert_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_n && !polarity) |-> (out_on == ~held));

    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |=> (stages == '0 && held == '0));

endmodule

// File: tb/test_serial_latch_driver.sv
`timescale 1ns/1ps
module test_serial_latch_driver;
    localparam int N = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shift_clk = 1'b1;
    logic         ser_din = 1'b0;
    logic         latch_en = 1'b0;
    logic         blank_n = 1'b1;
    logic         polarity = 1'b1;
    logic         ser_dout;
    logic [N-1:0] out_on;

    int checks = 0;
    int failures = 0;
    logic [N-1:0] m_sr = '0;
    logic [N-1:0] m_latch = '0;
    logic first_bit, second_bit;

    always #5 clk = ~clk;

    serial_latch_driver i_serial_latch_driver (
        .clk(clk), .rst_n(rst_n), .shift_clk(shift_clk), .ser_din(ser_din),
        .latch_en(latch_en), .blank_n(blank_n), .polarity(polarity),
        .ser_dout(ser_dout), .out_on(out_on)
    );

    function automatic logic [N-1:0] exp_out(logic [N-1:0] l, logic b, logic p);
        if (!b) return p ? '0 : '1;
        return p ? l : ~l;
    endfunction

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One full shift clock period; the model follows R1.
    task automatic shift_bit(input logic b);
        @(negedge clk);
        ser_din = b;
        wait_n(3);
        shift_clk = 1'b0;
        wait_n(4);
        shift_clk = 1'b1;
        wait_n(4);
        m_sr = {m_sr[N-2:0], b};
        if (latch_en) m_latch = m_sr;
    endtask

    task automatic set_le(input logic v);
        @(negedge clk);
        latch_en = v;
        wait_n(5);
        if (v) m_latch = m_sr;
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5A17));
        // R10: reset clears register and latches.
        wait_n(4);
        check("R10 reset latches", out_on, '0);
        check("R10 reset dout", {31'b0, ser_dout}, '0);
        @(negedge clk); rst_n = 1'b1;
        wait_n(2);

        // R1 R2 R3: shift 32 random bits while toggling controls.
        for (int i = 0; i < N; i++) begin
            logic b;
            b = 1'($urandom);
            if (i == 0) first_bit = b;
            if (i == 1) second_bit = b;
            blank_n  = 1'($urandom);
            polarity = 1'($urandom);
            shift_bit(b);
        end
        check("R2 dout after 32", {31'b0, ser_dout}, {31'b0, first_bit});
        blank_n = 1'b1; polarity = 1'b1; #1;
        check("R5 closed latch hides shifting", out_on, '0);
        shift_bit(1'($urandom));
        check("R2 dout after 33", {31'b0, ser_dout}, {31'b0, second_bit});

        // R4: open latch shows whole register (R1 R3 order).
        set_le(1'b1);
        check("R1 R3 register contents", out_on, m_sr);
        shift_bit(~m_sr[0]);
        check("R4 change under open latch", out_on, m_sr);

        // R5: closed latch holds through many shifts.
        set_le(1'b0);
        for (int i = 0; i < 8; i++) shift_bit(1'($urandom));
        check("R5 hold", out_on, m_latch);
        check("R2 dout tracks last stage", {31'b0, ser_dout}, {31'b0, m_sr[N-1]});

        // R6..R9 and R11: the four modes, checked 1 ns after the change.
        @(negedge clk);
        blank_n = 1'b0; polarity = 1'b0; #1;
        check("R6 R11 all on", out_on, '1);
        blank_n = 1'b0; polarity = 1'b1; #1;
        check("R7 R11 all off", out_on, '0);
        blank_n = 1'b1; polarity = 1'b1; #1;
        check("R8 R11 normal", out_on, m_latch);
        blank_n = 1'b1; polarity = 1'b0; #1;
        check("R9 R11 invert", out_on, ~m_latch);

        // Random mix of all features.
        for (int k = 0; k < 24; k++) begin
            set_le(1'($urandom));
            shift_bit(1'($urandom));
            @(negedge clk);
            blank_n  = 1'($urandom);
            polarity = 1'($urandom);
            #1;
            check("R4 R5 R6 R7 R8 R9 random", out_on, exp_out(m_latch, blank_n, polarity));
            check("R1 R2 random dout", {31'b0, ser_dout}, {31'b0, m_sr[N-1]});
        end

        // R10: reset mid-run clears register and latches.
        @(negedge clk); rst_n = 1'b0; latch_en = 1'b0;
        wait_n(2);
        blank_n = 1'b1; polarity = 1'b0; #1;
        check("R10 reset mid-run", out_on, '1);
        check("R10 reset dout mid-run", {31'b0, ser_dout}, '0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule